// File: doc/BRIEF.md
# Inductive Low-Side Channel Fault Supervisor

This block sits between the control logic and the gate driver of a low-side power switch that drives a solenoid-type load. It takes the channel command and three digitized fault flags: open load, overcurrent and overtemperature. It produces the gate enable and an active-low status line.

Each fault flag passes through a persistence filter. A filtered open load, seen only while the channel is commanded off, pulls the status line low. Only a rising command edge releases it. A filtered overcurrent latches the gate off and pulls the status line low. Only a falling command edge releases it, so the load re-energises at the next high command. Overtemperature forces the gate off and the status low for exactly as long as the flag is present, and needs no command edge to recover.

All inputs are sampled on the rising clock edge. Both outputs are registered, so each output reflects the inputs sampled one edge earlier. Filter lengths are given in clock cycles by parameters. The defaults correspond to 150 µs and 2 µs at 125 MHz.

Top module: `lowside_diag`

## Requirements
- R1: While rst_n is low at a clock edge, gate_en becomes 0 and status_n becomes 1 after that edge.
- R2: With no fault active or latched, gate_en after an edge equals cmd_in sampled at that edge.
- R3: The open-load filter counts only at edges where cmd_in is 0 and ol_flag is 1. status_n goes to 0 after the OL_CYC-th consecutive such edge, and not before. With cmd_in at 1, ol_flag has no effect on status_n.
- R4: An edge that samples ol_flag at 0, or cmd_in at 1, restarts the open-load count from zero.
- R5: A latched open load is released at the edge that samples cmd_in at 1 after an edge that sampled it at 0. status_n returns to 1 after that edge if no other fault is present.
- R6: When oc_flag is sampled at 1 on OC_CYC consecutive edges, gate_en is 0 and status_n is 0 after the last of those edges.
- R7: Once an overcurrent is latched, gate_en stays 0 and status_n stays 0 while cmd_in remains 1, whatever oc_flag does.
- R8: An overcurrent latch is cleared at the edge that samples cmd_in at 0 after an edge that sampled it at 1. status_n returns to 1 after it, and gate_en follows the next high command.
- R9: At each edge that samples ot_flag at 1, gate_en becomes 0 and status_n becomes 0. At the first edge with ot_flag at 0, both recover to their fault-free values without any command edge.
- R10: status_n is 1 exactly when no open load or overcurrent is latched and ot_flag was 0 at the last edge.
- R11: If a filtered fault completes at the same edge as the command edge that would clear it, the fault is kept latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_in | input | 1 | Channel on command |
| ol_flag | input | 1 | Open-load comparator result (drain below threshold while off) |
| oc_flag | input | 1 | Overcurrent comparator result |
| ot_flag | input | 1 | Overtemperature flag |
| gate_en | output | 1 | Gate drive enable |
| status_n | output | 1 | Diagnostic status, 0 means fault |

## Verification
The assertions assume that every input is synchronous to clk and is already free of metastability. They also assume that reset is held for at least one edge before release. The stimulus changes inputs only at the falling clock edge. It holds reset low for several edges at start. Fault flags in the random phase persist over many cycles, so both filters reach their limit and are also interrupted part way. Directed sequences line up filter completion with the clearing command edge, and keep command pulses short against latched faults.

// File: rtl/lowside_diag_pkg.sv
// Shared types for the low-side channel fault supervisor.
package lowside_diag_pkg;

    // Command transitions seen at one clock edge.
    typedef struct packed {
        logic rise;
        logic fall;
    } cmd_edge_t;

    // Fault state that feeds the output stage.
    typedef struct packed {
        logic open_load;
        logic over_current;
        logic over_temp;
    } fault_vec_t;

endpackage

// File: rtl/lowside_cmd_edge.sv
// Detects rising and falling transitions of the channel command.
// Assumes cmd_in is synchronous to clk. The edge outputs are combinational
// and valid in the cycle in which the new level is presented.
module lowside_cmd_edge
    import lowside_diag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_in,
    output cmd_edge_t edges
);

    logic cmd_q;

    // Hold the command level sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 1'b0;
        else        cmd_q <= cmd_in;
    end

    // Compare the present level against the held one.
    always_comb begin
        edges.rise = cmd_in & ~cmd_q;
        edges.fall = ~cmd_in & cmd_q;
    end

endmodule

// File: rtl/lowside_persist_filter.sv
// Persistence filter: hit is high at the LIMIT-th consecutive edge where
// raw is 1 and restart is 0, and at every further such edge.
// Assumes LIMIT >= 1. Any edge with raw low or restart high zeroes the count.
module lowside_persist_filter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic restart,
    output logic hit
);

    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;
    logic             clr;

    // Decide whether this edge breaks the run of qualifying samples.
    always_comb begin
        clr = restart | ~raw;
        hit = ~clr && (cnt == LAST);
    end

    // Count qualifying samples, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // R4: a broken run always starts the count again from zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || !raw) |=> (cnt == '0));

    // R3: the count never passes its limit
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/lowside_fault_latch.sv
// Set/clear latch for one fault. A set at the same edge as a clear wins.
// Provides the value the latch will hold after this edge (nxt) so the
// output stage can register it in step with the latch.
module lowside_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic q,
    output logic nxt
);

    // Set dominates clear; otherwise hold.
    always_comb begin
        if (set)        nxt = 1'b1;
        else if (clear) nxt = 1'b0;
        else            nxt = q;
    end

    // Store the fault state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

    // R11: a set is never lost, even next to a clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

endmodule

// File: rtl/lowside_diag.sv
// Fault supervisor for an inductive low-side channel.
// Filters open-load and overcurrent flags, latches them, and releases each on
// its own command edge (open load on rise, overcurrent on fall). Overtemperature
// acts directly. Assumes all inputs are synchronous to clk.
module lowside_diag
    import lowside_diag_pkg::*;
#(
    parameter int OL_CYC = 18750,
    parameter int OC_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_in,
    input  logic ol_flag,
    input  logic oc_flag,
    input  logic ot_flag,
    output logic gate_en,
    output logic status_n
);

    cmd_edge_t  edges;
    fault_vec_t fnext;
    logic       ol_hit, oc_hit;
    logic       ol_q, oc_q;
    logic       ol_nxt, oc_nxt;

    lowside_cmd_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_in (cmd_in),
        .edges  (edges)
    );

    // Open load is only judged while the channel is commanded off.
    lowside_persist_filter #(.LIMIT(OL_CYC)) u_ol_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (ol_flag),
        .restart (cmd_in),
        .hit     (ol_hit)
    );

    lowside_persist_filter #(.LIMIT(OC_CYC)) u_oc_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (oc_flag),
        .restart (1'b0),
        .hit     (oc_hit)
    );

    lowside_fault_latch u_ol_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ol_hit),
        .clear (edges.rise),
        .q     (ol_q),
        .nxt   (ol_nxt)
    );

    lowside_fault_latch u_oc_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (oc_hit),
        .clear (edges.fall),
        .q     (oc_q),
        .nxt   (oc_nxt)
    );

    // Gather the fault state that will hold after this edge.
    always_comb begin
        fnext.open_load    = ol_nxt;
        fnext.over_current = oc_nxt;
        fnext.over_temp    = ot_flag;
    end

    // Register the gate enable and status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_en  <= 1'b0;
            status_n <= 1'b1;
        end else begin
            gate_en  <= cmd_in & ~fnext.over_current & ~fnext.over_temp;
            status_n <= ~(|fnext);
        end
    end

    // R9: overtemperature forces both outputs to their fault state
    a_r9_ot_forces: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (!gate_en && !status_n));

    // R2: the gate is only on when the command was high
    a_r2_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> $past(cmd_in));

    // R7: a held overcurrent keeps the gate off until a falling command edge
    a_r7_oc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_q && !edges.fall) |=> (!gate_en && !status_n));

    // R8: a falling command edge without a new hit empties the overcurrent latch
    a_r8_oc_release: assert property (@(posedge clk) disable iff (!rst_n)
        (edges.fall && !oc_hit) |=> !oc_q);

    // R5: a rising command edge always empties the open-load latch
    a_r5_ol_release: assert property (@(posedge clk) disable iff (!rst_n)
        edges.rise |=> !ol_q);

    // R10: status only rises when overtemperature was absent
    a_r10_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_n) |-> !$past(ot_flag));

endmodule

// File: tb/lowside_diag_bench.sv
module lowside_diag_bench;

    localparam int OLN = 12;
    localparam int OCN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_in = 1'b0, ol_flag = 1'b0, oc_flag = 1'b0, ot_flag = 1'b0;
    logic gate_en, status_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    int m_olc = 0, m_occ = 0;
    bit m_ol = 0, m_oc = 0, m_cmdq = 0;
    bit e_gate = 0, e_stat = 1;

    always #4 clk = ~clk;

    lowside_diag #(.OL_CYC(OLN), .OC_CYC(OCN)) u_lowside_diag (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .ol_flag(ol_flag),
        .oc_flag(oc_flag), .ot_flag(ot_flag), .gate_en(gate_en), .status_n(status_n)
    );

    task automatic chk(input logic got, input bit exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_olc = 0; m_occ = 0; m_ol = 0; m_oc = 0; m_cmdq = 0;
        e_gate = 0; e_stat = 1;
    endtask

    // Expected outputs after one edge that samples the given inputs.
    task automatic model_step(input bit c, input bit l, input bit o, input bit t);
        bit rise, fall, lclr, ohit, lhit;
        rise = c & ~m_cmdq;
        fall = ~c & m_cmdq;
        lclr = c | ~l;
        lhit = !lclr && (m_olc == OLN - 1);
        ohit = o && (m_occ == OCN - 1);
        m_olc = lclr ? 0 : ((m_olc == OLN - 1) ? m_olc : m_olc + 1);
        m_occ = !o ? 0 : ((m_occ == OCN - 1) ? m_occ : m_occ + 1);
        m_ol = lhit ? 1'b1 : (rise ? 1'b0 : m_ol);
        m_oc = ohit ? 1'b1 : (fall ? 1'b0 : m_oc);
        e_gate = c & ~m_oc & ~t;
        e_stat = ~(m_ol | m_oc | t);
        m_cmdq = c;
    endtask

    // Apply one cycle of inputs and compare both outputs after the edge.
    task automatic step(input bit c, input bit l, input bit o, input bit t, input string tag);
        @(negedge clk);
        cmd_in = c; ol_flag = l; oc_flag = o; ot_flag = t;
        model_step(c, l, o, t);
        @(posedge clk);
        #2;
        chk(gate_en, e_gate, {tag, " gate_en"});
        chk(status_n, e_stat, {tag, " status_n"});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit c, l, o, t;
        void'($urandom(32'h5eed_1a7e));
        model_reset();
        // R1: reset state
        cmd_in = 1'b1; ot_flag = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(gate_en, 1'b0, "R1 gate_en in reset");
        chk(status_n, 1'b1, "R1 status_n in reset");
        @(negedge clk);
        cmd_in = 1'b0;
        rst_n = 1'b1;

        // R2: command followed with no faults
        for (int i = 0; i < 6; i++) step(i[0], 0, 0, 0, "R2");

        // R3: flag ignored while commanded on
        for (int i = 0; i < 2 * OLN; i++) step(1, 1, 0, 0, "R3 cmd-high");
        // R3: count to the limit while off
        for (int i = 0; i < OLN - 1; i++) step(0, 1, 0, 0, "R3 pre-limit");
        step(0, 1, 0, 0, "R3 at limit");
        chk(status_n, 1'b0, "R3 open load reported");
        // R5: rising command edge releases it
        step(1, 1, 0, 0, "R5 release");
        chk(status_n, 1'b1, "R5 status restored");
        // R4: interrupted run restarts
        for (int i = 0; i < OLN - 1; i++) step(0, 1, 0, 0, "R4 run a");
        step(0, 0, 0, 0, "R4 gap");
        for (int i = 0; i < OLN - 1; i++) step(0, 1, 0, 0, "R4 run b");
        chk(status_n, 1'b1, "R4 no report after restart");
        step(0, 0, 0, 0, "R4 idle");

        // R6: overcurrent filtered
        step(1, 0, 0, 0, "R6 on");
        for (int i = 0; i < OCN - 1; i++) step(1, 0, 1, 0, "R6 pre-limit");
        step(1, 0, 1, 0, "R6 at limit");
        chk(gate_en, 1'b0, "R6 gate latched off");
        // R7: held while command stays high
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R7 hold");
        chk(status_n, 1'b0, "R7 status held");
        // R8: falling edge clears, next high re-enables
        step(0, 0, 0, 0, "R8 fall");
        chk(status_n, 1'b1, "R8 status restored");
        step(1, 0, 0, 0, "R8 re-enable");
        chk(gate_en, 1'b1, "R8 gate back on");

        // R9: overtemperature direct and self-recovering
        step(1, 0, 0, 1, "R9 hot");
        chk(gate_en, 1'b0, "R9 gate off");
        step(1, 0, 0, 1, "R9 hot");
        step(1, 0, 0, 0, "R9 cool");
        chk(gate_en, 1'b1, "R9 gate recovered");

        // R11: overcurrent completes on the falling edge itself
        for (int i = 0; i < OCN - 1; i++) step(1, 0, 1, 0, "R11 pre");
        step(0, 0, 1, 0, "R11 collide");
        chk(status_n, 1'b0, "R11 fault kept");
        step(1, 0, 0, 0, "R11 held");
        chk(gate_en, 1'b0, "R11 gate still off");
        step(0, 0, 0, 0, "R11 clear");

        // R10: random sustained flags
        c = 0; l = 0; o = 0; t = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) c = ~c;
            if ($urandom_range(15) == 0) l = ~l;
            if ($urandom_range(9) == 0) o = ~o;
            if ($urandom_range(40) == 0) t = ~t;
            step(c, l, o, t, "R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule